// File: doc/BRIEF.md
# Adder-Subtractor ALU with Zero Flag

This block is the arithmetic-logic unit of a small load/store processor. It takes two operands and a 3-bit operation code and produces a result word, a zero flag and the carry out of the top adder bit. It offers bitwise AND, bitwise OR, addition, subtraction and a signed set-less-than. The unit is purely combinational: its outputs follow its inputs with no clock and no stored state.

There is a single adder, built as a ripple chain of one-bit full adders. Each B bit first passes through an XOR gate, and that XOR acts as a conditional inverter. When the operation asks for subtraction, every B bit is complemented and the carry into bit 0 is forced high, which gives A minus B in two's complement. Set-less-than uses the same subtraction. The processor tests two registers for equality by issuing a subtract and reading the zero flag, so there is no separate comparator.

Top module: `addsub_alu`

## Requirements
- R1: With op code 3'b000 the result is the bitwise AND of the two operands.
- R2: With op code 3'b001 the result is the bitwise OR of the two operands.
- R3: With op code 3'b010 the result is A + B modulo 2^32, and carry_out is bit 32 of the unsigned sum.
- R4: With op code 3'b110 the result is A - B modulo 2^32. The adder produces it by inverting B and setting the carry into bit 0.
- R5: With op code 3'b111 the result is 1 when A is less than B as signed two's-complement numbers, and 0 otherwise. Bits 31 down to 1 are always 0. The comparison stays correct when A - B overflows, for example 0x80000000 against 0x7FFFFFFF.
- R6: Op codes 3'b011, 3'b100 and 3'b101 give a result of 0.
- R7: The zero flag is 1 exactly when all 32 result bits are 0. This holds for every op code, including the codes that give 0 under R6.
- R8: A subtract of two equal operands sets the zero flag, and a subtract of two unequal operands clears it.
- R9: For op codes 3'b110 and 3'b111, carry_out is 1 exactly when A >= B as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| carry_out | output | 1 | Carry out of bit 31 of the adder chain |

## Verification
The checks inside the block assume that every input bit carries a known 0 or 1. They are evaluated continuously, so they also assume that the inputs change only at points where the outputs have time to settle before anything samples them. The stimulus therefore drives fully defined operands and all eight op codes, including the three codes that give 0. It changes inputs only just after a rising clock edge and compares outputs at the following falling edge. The operands mix random values with the signed and unsigned extremes, where the overflow correction in set-less-than and the carry out are most easily wrong.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W  = 32;
  localparam int unsigned OP_W   = 3;

  typedef logic [OP_W-1:0] alu_op_t;

  localparam alu_op_t OP_AND = 3'b000;
  localparam alu_op_t OP_OR  = 3'b001;
  localparam alu_op_t OP_ADD = 3'b010;
  localparam alu_op_t OP_SUB = 3'b110;
  localparam alu_op_t OP_SLT = 3'b111;

  // Bit of the op code that selects inversion of B in the adder chain.
  localparam int unsigned SUB_BIT = 2;
endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic in_x,
  input  logic in_y,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);
  logic prop;
  assign prop  = in_x ^ in_y;
  assign s_out = prop ^ c_in;
  assign c_out = (in_x & in_y) | (prop & c_in);
endmodule

// File: rtl/alu_ripple_addsub.sv
module alu_ripple_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic y_cond;
      logic cin_w;
      logic cout_w;
      logic s_w;

      // XOR used as a conditional inverter on the B side.
      assign y_cond = y_i[i] ^ sub_i;

      if (i == 0) begin : g_first
        assign cin_w = sub_i;
      end else begin : g_rest
        assign cin_w = g_bit[i-1].cout_w;
      end

      alu_full_adder u_fa (
        .in_x  (x_i[i]),
        .in_y  (y_cond),
        .c_in  (cin_w),
        .s_out (s_w),
        .c_out (cout_w)
      );

      assign sum_o[i] = s_w;
    end
  endgenerate

  assign cout_o = g_bit[MSB].cout_w;
  assign ovf_o  = g_bit[MSB].cin_w ^ g_bit[MSB].cout_w;
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  assign and_o = x_i & y_i;
  assign or_o  = x_i | y_i;
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_t          op_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             lt_i,
  output logic [WIDTH-1:0] res_o
);
  localparam logic [WIDTH-1:0] ZERO_W = '0;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = and_i;
      OP_OR:   res_o = or_i;
      OP_ADD:  res_o = sum_i;
      OP_SUB:  res_o = sum_i;
      OP_SLT:  res_o = {ZERO_W[WIDTH-1:1], lt_i};
      default: res_o = ZERO_W;
    endcase
  end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             sub_mode;
  logic [WIDTH-1:0] sum_w;
  logic             ovf_w;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic             lt_w;

  assign sub_mode = op_sel[SUB_BIT];

  alu_ripple_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x_i    (opnd_a),
    .y_i    (opnd_b),
    .sub_i  (sub_mode),
    .sum_o  (sum_w),
    .cout_o (carry_out),
    .ovf_o  (ovf_w)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .x_i   (opnd_a),
    .y_i   (opnd_b),
    .and_o (and_w),
    .or_o  (or_w)
  );

  // Signed less-than: sign of the difference, corrected on overflow.
  assign lt_w = sum_w[MSB] ^ ovf_w;

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .op_i  (op_sel),
    .and_i (and_w),
    .or_i  (or_w),
    .sum_i (sum_w),
    .lt_i  (lt_w),
    .res_o (result)
  );

  assign zero = ~|result;
endmodule

// File: rtl/addsub_alu_checker.sv
module addsub_alu_checker
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [OP_W-1:0]  op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             carry_out
);
  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
      // R7
      p_zero_flag_r7: assert (zero == (result == '0))
        else $error("zero flag does not match result");
      // R5
      if (op_sel == OP_SLT) begin
        p_slt_upper_r5: assert (result[WIDTH-1:1] == '0)
          else $error("set-less-than upper bits not zero");
      end
      // R6
      if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101) begin
        p_undef_zero_r6: assert (result == '0 && zero)
          else $error("undefined op code gave a nonzero result");
      end
      // R8
      if (op_sel == OP_SUB) begin
        p_equal_sub_r8: assert (zero == (opnd_a == opnd_b))
          else $error("subtract zero flag disagrees with equality");
      end
      // R9
      if (op_sel == OP_SUB || op_sel == OP_SLT) begin
        p_sub_carry_r9: assert (carry_out == (opnd_a >= opnd_b))
          else $error("subtract carry disagrees with unsigned compare");
      end
      // R3
      if (op_sel == OP_ADD) begin
        p_add_sum_r3: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
          else $error("add result or carry wrong");
      end
    end
  end
endmodule

bind addsub_alu addsub_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_sel    (op_sel),
  .result    (result),
  .zero      (zero),
  .carry_out (carry_out)
);

// File: tb/addsub_alu_bench.sv
`timescale 1ns/1ps
module addsub_alu_bench;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [2:0]   op_in = '0;
  logic [W-1:0] res;
  logic         zf;
  logic         cf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addsub_alu u_addsub_alu (
    .opnd_a    (a_in),
    .opnd_b    (b_in),
    .op_sel    (op_in),
    .result    (res),
    .zero      (zf),
    .carry_out (cf)
  );

  function automatic logic [W-1:0] exp_res(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (op)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b110:  return a - b;
      3'b111:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_carry(input logic [2:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    logic [W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    if (op == 3'b010) return wide[W];
    return (a >= b);
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: op=%b a=%h b=%h actual=%h expected=%h", tag, op_in, a_in, b_in, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    @(posedge clk);
    #0.5;
    op_in = op; a_in = a; b_in = b;
    @(negedge clk);
    er = exp_res(op, a, b);
    check_val(op_tag(op), res, er);
    check_val("R7", {31'd0, zf}, {31'd0, (er == '0)});
    if (op == 3'b110 && a == b)
      check_val("R8", {31'd0, zf}, 32'd1);
    if (op == 3'b010 || op == 3'b110 || op == 3'b111)
      check_val(op == 3'b010 ? "R3" : "R9", {31'd0, cf}, {31'd0, exp_carry(op, a, b)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] corner [0:5];
    logic [2:0]   ops [0:7];
    void'($urandom(32'h5EED_0A1C));
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001; corner[5] = 32'h1234_5678;
    for (int k = 0; k < 8; k++) ops[k] = 3'(k);

    repeat (4) @(posedge clk);
    rst = 1'b0;

    // Idle state: all-zero inputs select AND of zeros (R1, R7).
    @(negedge clk);
    check_val("R1", res, 32'd0);
    check_val("R7", {31'd0, zf}, 32'd1);

    // Directed cases
    apply(3'b111, 32'h8000_0000, 32'h7FFF_FFFF); // R5 overflow: expect 1
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000); // R5 overflow: expect 0
    apply(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF); // R8 equal
    apply(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEE); // R8 unequal
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001); // R3 wrap, carry
    apply(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R6
    apply(3'b100, 32'h1234_5678, 32'h0000_0001); // R6
    apply(3'b101, 32'hFFFF_FFFF, 32'h0000_0000); // R6
    apply(3'b110, 32'h0000_0000, 32'h0000_0001); // R4, R9 borrow

    // Every op over every corner pair
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(ops[o], corner[i], corner[j]);

    // Random operands, sometimes forced equal or near a corner
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = $urandom();
      rb = $urandom();
      if (($urandom() % 8) == 0) rb = ra;
      if (($urandom() % 8) == 1) ra = corner[$urandom() % 6];
      apply(3'($urandom()), ra, rb);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule